// File: doc/BRIEF.md
# Prescaled Timer with Match Actions

This block is a general-purpose up-counting timer. In timer mode a prescale counter divides the peripheral clock, and every time the prescale counter reaches its programmed limit the main count advances by one. In counter mode the main count advances instead on edges seen on one of three capture inputs. The capture inputs are synchronized and edge-detected inside the block. Software selects the edge polarity and the input.

Four match registers are compared against the count at all times. Each match has its own three action bits, and any mix of them may be set. The interrupt action raises a sticky flag. The reset action returns the count to zero in place of the next increment. The stop action clears the enable bit and leaves the count frozen at the match value. Match actions are taken on a count tick in which the count equals the match value. A single interrupt line reports the OR of the four flags.

Software reaches the block through a simple port. A write port updates one register per clock. A combinational read port returns any register selected by a read address.

Top module: `ptmr_top`

## Requirements
- R1: With prescale limit p (address 0x2), the count (address 0x1) advances once every p+1 clocks while enabled in timer mode. The prescale counter (address 0x3, read-only) steps 0,1,…,p and returns to 0 on the clock at which the count advances.
- R2: The count rolls over from 0xFFFFFFFF to 0, and the rollover sets no interrupt flag.
- R3: Control register (address 0x0) bit 0 is the enable and bit 1 is the hold-in-reset. With bit 0 clear the count stays unchanged. While bit 1 is set, both the count and the prescale counter read as zero. After reset, the control register, the count, the prescale counter and the interrupt output are all zero.
- R4: Match-control register (address 0x4) bit 3i enables the interrupt action for match i. A tick at which the count equals match i (address 0x8+i) sets flag i in the flag register (address 0x6). A flag stays set until a 1 is written to its bit, and writing 0 leaves it alone. The interrupt output is high when any flag is set.
- R5: Match-control bit 3i+1 makes a tick at which the count equals match i load zero instead of incrementing.
- R6: Match-control bit 3i+2 makes a tick at which the count equals match i clear the enable bit, with the count left at the match value.
- R7: Count-control register (address 0x5) bits 1:0 choose the source. 00 is timer mode. 01 counts rising edges, 10 counts falling edges and 11 counts both, on the selected capture input. In counter mode the prescale counter stays at zero.
- R8: Count-control bits 3:2 select capture input 0, 1 or 2 (codes 00, 01, 10). Code 11 selects input 0. Edges on inputs that are not selected have no effect on the count.
- R9: Reserved register bits and unused addresses read as zero. The control register keeps 2 bits, match-control keeps 12 bits and count-control keeps 4 bits.
- R10: A write to address 0x1 loads the count directly. Such a write takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data for rd_addr (combinational) |
| cap_i | input | 3 | Asynchronous capture inputs used as count sources |
| irq_o | output | 1 | OR of the four match interrupt flags |

## Verification
The hardest state to reach from the ports is the count rollover. The count would need about four billion ticks to get there by counting. The bench instead loads the count just below all-ones through the direct write and then lets two ticks carry it across zero. During those ticks no interrupt action is enabled, so the interrupt line must stay low. Counter mode is the other awkward area because of its three-clock synchronizer latency. The bench drives shaped pulses on selected and unselected inputs, waits out the latency and compares the edge total for each polarity.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'h0;
    localparam logic [ADDR_W-1:0] A_TC    = 4'h1;
    localparam logic [ADDR_W-1:0] A_PR    = 4'h2;
    localparam logic [ADDR_W-1:0] A_PC    = 4'h3;
    localparam logic [ADDR_W-1:0] A_MCTL  = 4'h4;
    localparam logic [ADDR_W-1:0] A_CCTL  = 4'h5;
    localparam logic [ADDR_W-1:0] A_IFLAG = 4'h6;
    localparam logic [ADDR_W-1:0] A_MR0   = 4'h8;

    // action bit offsets inside each match's 3-bit group
    localparam int ACT_INT  = 0;
    localparam int ACT_RST  = 1;
    localparam int ACT_STOP = 2;
    localparam int ACT_W    = 3;

    typedef enum logic [1:0] {
        CM_TIMER = 2'b00,
        CM_RISE  = 2'b01,
        CM_FALL  = 2'b10,
        CM_BOTH  = 2'b11
    } cnt_mode_e;
endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         run_i,
    input  logic [W-1:0] limit_i,
    output logic         tick_o,
    output logic [W-1:0] pc_o
);
    logic [W-1:0] pc_d, pc_q;

    always_comb begin
        // >= keeps the counter bounded when the limit is lowered mid-count
        tick_o = run_i && !clr_i && (pc_q >= limit_i);
        pc_d   = pc_q;
        if (clr_i)       pc_d = '0;
        else if (tick_o) pc_d = '0;
        else if (run_i)  pc_d = pc_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign pc_o = pc_q;
endmodule

// File: rtl/ptmr_cap_edge.sv
module ptmr_cap_edge
    import ptmr_pkg::*;
#(
    parameter int N_CAP = 3,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CAP-1:0] cap_i,
    input  logic [SEL_W-1:0] sel_i,
    input  cnt_mode_e        mode_i,
    output logic             pulse_o
);
    typedef struct packed {
        logic [N_CAP-1:0] meta;
        logic [N_CAP-1:0] sync;
        logic [N_CAP-1:0] prev;
    } edge_st_t;

    edge_st_t s_d, s_q;
    logic [SEL_W-1:0] sel_eff;
    logic cur, old;

    always_comb begin
        s_d.meta = cap_i;
        s_d.sync = s_q.meta;
        s_d.prev = s_q.sync;

        sel_eff = (int'(sel_i) < N_CAP) ? sel_i : '0;
        cur = s_q.sync[sel_eff];
        old = s_q.prev[sel_eff];

        case (mode_i)
            CM_RISE: pulse_o = cur & ~old;
            CM_FALL: pulse_o = ~cur & old;
            CM_BOTH: pulse_o = cur ^ old;
            default: pulse_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/ptmr_match.sv
module ptmr_match
    import ptmr_pkg::*;
#(
    parameter int W       = 32,
    parameter int N_MATCH = 4,
    localparam int MCTL_W = N_MATCH * ACT_W
) (
    input  logic [W-1:0]              tc_i,
    input  logic [N_MATCH-1:0][W-1:0] mr_i,
    input  logic [MCTL_W-1:0]         act_i,
    output logic [N_MATCH-1:0]        int_hit_o,
    output logic                      rst_any_o,
    output logic                      stop_any_o
);
    logic [N_MATCH-1:0] rst_vec, stop_vec;

    for (genvar i = 0; i < N_MATCH; i++) begin : g_cmp
        logic eq;
        assign eq          = (tc_i == mr_i[i]);
        assign int_hit_o[i] = eq & act_i[i*ACT_W + ACT_INT];
        assign rst_vec[i]   = eq & act_i[i*ACT_W + ACT_RST];
        assign stop_vec[i]  = eq & act_i[i*ACT_W + ACT_STOP];
    end

    assign rst_any_o  = |rst_vec;
    assign stop_any_o = |stop_vec;
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int W       = 32,
    parameter int N_MATCH = 4,
    parameter int N_CAP   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    input  logic [N_CAP-1:0]  cap_i,
    output logic              irq_o
);
    localparam int MCTL_W = N_MATCH * ACT_W;
    localparam int SEL_W  = 2;

    typedef struct packed {
        logic                      en;
        logic                      hold;
        logic [W-1:0]              pr;
        logic [W-1:0]              tc;
        logic [N_MATCH-1:0][W-1:0] mr;
        logic [MCTL_W-1:0]         mctl;
        cnt_mode_e                 mode;
        logic [SEL_W-1:0]          sel;
        logic [N_MATCH-1:0]        flag;
    } tmr_st_t;

    tmr_st_t s_d, s_q;

    logic               count_en, timer_mode;
    logic               pre_tick, cap_pulse, tick;
    logic [W-1:0]       pc_w;
    logic [N_MATCH-1:0] int_hit, set_flags, clr_flags;
    logic               rst_any, stop_any;

    // flat views of state for the bound checker
    logic               en_q, hold_q;
    logic [W-1:0]       tc_q;
    logic [N_MATCH-1:0] flag_q;
    assign en_q   = s_q.en;
    assign hold_q = s_q.hold;
    assign tc_q   = s_q.tc;
    assign flag_q = s_q.flag;

    assign count_en   = s_q.en & ~s_q.hold;
    assign timer_mode = (s_q.mode == CM_TIMER);

    ptmr_prescale #(.W(W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (s_q.hold | ~timer_mode),
        .run_i   (count_en & timer_mode),
        .limit_i (s_q.pr),
        .tick_o  (pre_tick),
        .pc_o    (pc_w)
    );

    ptmr_cap_edge #(.N_CAP(N_CAP), .SEL_W(SEL_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (cap_i),
        .sel_i   (s_q.sel),
        .mode_i  (s_q.mode),
        .pulse_o (cap_pulse)
    );

    ptmr_match #(.W(W), .N_MATCH(N_MATCH)) u_cmp (
        .tc_i       (s_q.tc),
        .mr_i       (s_q.mr),
        .act_i      (s_q.mctl),
        .int_hit_o  (int_hit),
        .rst_any_o  (rst_any),
        .stop_any_o (stop_any)
    );

    assign tick = timer_mode ? pre_tick : (count_en & cap_pulse);

    always_comb begin
        s_d       = s_q;
        set_flags = tick ? int_hit : '0;
        clr_flags = '0;

        // count step on a tick: reset action beats stop, stop freezes
        if (tick) begin
            if (rst_any)       s_d.tc = '0;
            else if (!stop_any) s_d.tc = s_q.tc + W'(1);
        end

        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    s_d.en   = wr_data[0];
                    s_d.hold = wr_data[1];
                end
                A_TC:    s_d.tc   = wr_data;
                A_PR:    s_d.pr   = wr_data;
                A_MCTL:  s_d.mctl = wr_data[MCTL_W-1:0];
                A_CCTL: begin
                    s_d.mode = cnt_mode_e'(wr_data[1:0]);
                    s_d.sel  = wr_data[3:2];
                end
                A_IFLAG: clr_flags = wr_data[N_MATCH-1:0];
                default: ;
            endcase
        end

        for (int i = 0; i < N_MATCH; i++) begin
            if (wr_en && (wr_addr == A_MR0 + ADDR_W'(i))) s_d.mr[i] = wr_data;
        end

        // a new event wins over a same-cycle clear
        s_d.flag = (s_q.flag & ~clr_flags) | set_flags;

        if (tick && stop_any) s_d.en = 1'b0;
        if (s_q.hold)         s_d.tc = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:  rd_data = W'({s_q.hold, s_q.en});
            A_TC:    rd_data = s_q.tc;
            A_PR:    rd_data = s_q.pr;
            A_PC:    rd_data = pc_w;
            A_MCTL:  rd_data = W'(s_q.mctl);
            A_CCTL:  rd_data = W'({s_q.sel, s_q.mode});
            A_IFLAG: rd_data = W'(s_q.flag);
            default: ;
        endcase
        for (int i = 0; i < N_MATCH; i++) begin
            if (rd_addr == A_MR0 + ADDR_W'(i)) rd_data = s_q.mr[i];
        end
    end

    assign irq_o = |s_q.flag;
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker
    import ptmr_pkg::*;
#(
    parameter int W       = 32,
    parameter int N_MATCH = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [N_MATCH-1:0] clr_bits,
    input logic               en_q,
    input logic               hold_q,
    input logic [W-1:0]       tc_q,
    input logic [W-1:0]       pc_q,
    input logic [N_MATCH-1:0] flag_q,
    input logic               tick,
    input logic               rst_any,
    input logic               stop_any
);
    logic tc_wr;
    assign tc_wr = wr_en && (wr_addr == A_TC);

    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !rst_any && !stop_any && !tc_wr) |=> (tc_q == $past(tc_q) + W'(1)))
        else $error("R1 count did not advance on tick");

    a_r1_pc_restart: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pc_q == '0))
        else $error("R1 prescale counter not zero after tick");

    a_r2_rollover: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (tc_q == '1) && !rst_any && !stop_any && !tc_wr) |=> (tc_q == '0))
        else $error("R2 rollover missed");

    a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !hold_q && !tc_wr) |=> $stable(tc_q))
        else $error("R3 count moved while disabled");

    a_r3_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |=> (tc_q == '0 && pc_q == '0))
        else $error("R3 counters not held at zero");

    for (genvar i = 0; i < N_MATCH; i++) begin : g_flag
        a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !(wr_en && wr_addr == A_IFLAG && clr_bits[i])) |=> flag_q[i])
            else $error("R4 flag dropped without clear");
    end

    a_r5_reset_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rst_any && !tc_wr) |=> (tc_q == '0))
        else $error("R5 count not reset on match");

    a_r6_stop_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && stop_any) |=> !en_q)
        else $error("R6 enable not cleared on match");
endmodule

bind ptmr_top ptmr_checker #(.W(W), .N_MATCH(N_MATCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .clr_bits (wr_data[N_MATCH-1:0]),
    .en_q     (en_q),
    .hold_q   (hold_q),
    .tc_q     (tc_q),
    .pc_q     (pc_w),
    .flag_q   (flag_q),
    .tick     (tick),
    .rst_any  (rst_any),
    .stop_any (stop_any)
);

// File: tb/ptmr_top_test.sv
module ptmr_top_test;
    import ptmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [2:0]  cap = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ptmr_top uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cap_i   (cap),
        .irq_o   (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1 check(tag, rd_data, exp);
    endtask

    task automatic restart(input logic [31:0] p);
        wr(A_CTRL, 32'h2);
        wr(A_IFLAG, 32'hF);
        wr(A_PR, p);
        wr(A_CTRL, 32'h1);
    endtask

    task automatic pulse(input int idx, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); cap[idx] = 1'b1;
            repeat (3) @(negedge clk);
            cap[idx] = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        run(0);
        rd_chk("R3 reset ctrl", A_CTRL, 0);
        rd_chk("R3 reset count", A_TC, 0);
        rd_chk("R3 reset prescale", A_PC, 0);
        check("R3 reset irq", 32'(irq), 0);
    endtask

    task automatic t_prescale;
        restart(2);
        run(10);
        rd_chk("R1 p=2 count after 10", A_TC, 3);
        rd_chk("R1 p=2 prescale after 10", A_PC, 1);
        run(2);
        rd_chk("R1 p=2 count after 12", A_TC, 4);
        rd_chk("R1 p=2 prescale after 12", A_PC, 0);
        restart(0);
        run(7);
        rd_chk("R1 p=0 count after 7", A_TC, 7);
    endtask

    task automatic t_wrap;
        wr(A_TC, 32'hFFFF_FFFE);
        run(0);
        rd_chk("R10 direct load", A_TC, 32'hFFFF_FFFE);
        run(1);
        rd_chk("R2 all ones", A_TC, 32'hFFFF_FFFF);
        run(1);
        rd_chk("R2 wrapped to zero", A_TC, 0);
        check("R2 no irq on wrap", 32'(irq), 0);
    endtask

    task automatic t_enable;
        logic [31:0] snap;
        wr(A_CTRL, 32'h0);
        run(0);
        rd_addr = A_TC;
        #1 snap = rd_data;
        run(5);
        rd_chk("R3 disabled count frozen", A_TC, snap);
        wr(A_CTRL, 32'h3);
        run(3);
        rd_chk("R3 hold count zero", A_TC, 0);
        rd_chk("R3 hold prescale zero", A_PC, 0);
    endtask

    task automatic t_match_int;
        wr(A_MR0, 5);
        wr(A_MR0 + 4'd3, 2);
        wr(A_MCTL, 32'h201);
        restart(0);
        run(2);
        check("R4 no irq before match", 32'(irq), 0);
        run(1);
        rd_chk("R4 flag3 set", A_IFLAG, 32'h8);
        check("R4 irq high", 32'(irq), 1);
        run(3);
        rd_chk("R4 flag0 and flag3", A_IFLAG, 32'h9);
        wr(A_IFLAG, 32'h0);
        run(0);
        rd_chk("R4 zero write keeps flags", A_IFLAG, 32'h9);
        wr(A_IFLAG, 32'h8);
        run(0);
        rd_chk("R4 clear flag3 only", A_IFLAG, 32'h1);
        wr(A_IFLAG, 32'h1);
        run(0);
        rd_chk("R4 all clear", A_IFLAG, 0);
        check("R4 irq low", 32'(irq), 0);
    endtask

    task automatic t_match_rst;
        wr(A_MCTL, 32'h10);
        wr(A_MR0 + 4'd1, 3);
        restart(0);
        run(6);
        rd_chk("R5 count mod 4 after 6", A_TC, 2);
        run(4);
        rd_chk("R5 count mod 4 after 10", A_TC, 2);
        check("R5 no irq", 32'(irq), 0);
        restart(1);
        run(8);
        rd_chk("R5 p=1 reset count", A_TC, 0);
        rd_chk("R5 p=1 prescale", A_PC, 0);
        run(1);
        rd_chk("R5 p=1 prescale next", A_PC, 1);
    endtask

    task automatic t_match_stop;
        wr(A_MCTL, 32'h100);
        wr(A_MR0 + 4'd2, 4);
        restart(0);
        run(8);
        rd_chk("R6 frozen at match", A_TC, 4);
        rd_chk("R6 enable cleared", A_CTRL, 0);
    endtask

    task automatic t_counter;
        wr(A_MCTL, 32'h0);
        wr(A_CTRL, 32'h2);
        wr(A_CCTL, 32'h5);
        wr(A_CTRL, 32'h1);
        pulse(1, 4);
        pulse(0, 2);
        pulse(2, 2);
        run(4);
        rd_chk("R7 rising edges on input 1", A_TC, 4);
        rd_chk("R7 prescale idle in counter mode", A_PC, 0);
        wr(A_CTRL, 32'h2);
        wr(A_CCTL, 32'hA);
        wr(A_CTRL, 32'h1);
        pulse(2, 3);
        run(4);
        rd_chk("R7 falling edges on input 2", A_TC, 3);
        wr(A_CTRL, 32'h2);
        wr(A_CCTL, 32'hF);
        wr(A_CTRL, 32'h1);
        pulse(0, 2);
        pulse(1, 1);
        run(4);
        rd_chk("R8 select 11 uses input 0 both edges", A_TC, 4);
    endtask

    task automatic t_reserved;
        wr(A_CTRL, 32'h0);
        wr(A_CCTL, 32'hFFFF_FFFF);
        run(0);
        rd_chk("R9 count-control width", A_CCTL, 32'hF);
        wr(A_MCTL, 32'hFFFF_FFFF);
        run(0);
        rd_chk("R9 match-control width", A_MCTL, 32'hFFF);
        rd_chk("R9 unused address", 4'h7, 0);
        wr(A_CTRL, 32'hFFFF_FFFC);
        run(0);
        rd_chk("R9 control width", A_CTRL, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_prescale();
        t_wrap();
        t_enable();
        t_match_int();
        t_match_rst();
        t_match_stop();
        t_counter();
        t_reserved();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule